// File: doc/BRIEF.md
# External Interrupt Trigger Controller

The block watches a small group of external interrupt pins and turns each one into a request that the rest of the chip can service. Every pin first passes through a synchronizer. A per-line trigger unit then either follows the pin level or records an edge event, depending on how software has configured that line. Five trigger modes are available: high level, low level, rising edge, falling edge and any edge.

Software uses a plain register port to reach the per-line controls. Each register serves four lines, and register `k` holds lines `4k` to `4k+3`. Through it software sets the trigger mode and the enable of each line. It also acknowledges a recorded edge by writing 1 to that line's clear bit. The block drives one masked request per line and a single combined request.

Each line runs a two-state machine. `LN_IDLE` means no edge event is recorded. `LN_LATCHED` means an edge event is waiting to be acknowledged. The transitions are:
- *capture*: `LN_IDLE` to `LN_LATCHED`, on a matching edge while the line is in an edge mode.
- *ack*: `LN_LATCHED` to `LN_IDLE`, on a clear write when no new edge arrives in the same cycle.
- *retrigger*: `LN_LATCHED` stays in `LN_LATCHED`, when a new edge arrives in the same cycle as a clear.
- *level_flush*: any state to `LN_IDLE`, while the line is in a level mode.

Top module: `xirq_trigger_ctrl`

## Requirements
- R1: After reset every line reads back as active-low level (level-select 1, sense 0, any-edge 0) with its enable bit 0, and all request outputs are low.
- R2: With level-select 1, a line's request equals (synchronized pin == sense bit): sense 1 gives active high and sense 0 gives active low. The request follows a pin change two clock edges after the pin is sampled.
- R3: With level-select 0 and any-edge 0, sense 1 records a rising edge and sense 0 records a falling edge. Once recorded, the event holds whatever the pin does afterwards.
- R4: With level-select 0 and any-edge 1, both rising and falling edges are recorded.
- R5: A line's request output is high only when its enable bit is 1. An edge that arrives while the enable bit is 0 is still recorded, and it appears on the output once the line is enabled.
- R6: A register write with a line's clear bit set to 1 drops that line's recorded edge event. In a level mode the clear bit has no effect, and the request stays high while the level stays active.
- R7: Register layout: line `i` lives in register `i/4`, in slot `s = i%4`. Slot `s` uses these bits: enable at `s`, clear at `4+s`, sense at `8+s`, level-select at `12+s`, any-edge at `16+s`. Clear bits and slots with no line read back as 0. A write updates all fields of the lines in the addressed register.
- R8: The combined request is the OR of all masked per-line requests.
- R9: When level-select is 1, the any-edge bit is ignored and the line behaves as a level line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register index for the write |
| wr_data | input | 20 | Write data (layout given in R7) |
| rd_addr | input | ADDR_W | Register index for the read |
| rd_data | output | 20 | Combinational read data |
| line_req | output | NUM_LINES | Per-line masked request |
| any_req | output | 1 | OR of all line requests |

## Verification
The bench builds the block with six lines, which spreads the lines over two registers. This exercises the second register, the partly filled slots in that register, and slot decoding modulo four. With these values, a random mix of pin toggles and configuration writes reaches every mode on lines in both registers. It also covers mode changes while an edge event is recorded.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int LINES_PER_REG = 4;
    localparam int FIELDS        = 5;
    localparam int REG_W         = FIELDS * LINES_PER_REG;
    localparam int OFS_EN        = 0;
    localparam int OFS_CLR       = LINES_PER_REG;
    localparam int OFS_SENSE     = 2 * LINES_PER_REG;
    localparam int OFS_LEVEL     = 3 * LINES_PER_REG;
    localparam int OFS_ANY       = 4 * LINES_PER_REG;

    typedef struct packed {
        logic level;
        logic sense;
        logic any_edge;
        logic enable;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{level: 1'b1, sense: 1'b0, any_edge: 1'b0, enable: 1'b0};

    typedef enum logic [0:0] {
        LN_IDLE    = 1'b0,
        LN_LATCHED = 1'b1
    } line_state_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 6,
    parameter int ADDR_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output line_cfg_t         cfg_o [NUM_LINES],
    output logic [NUM_LINES-1:0] clr_o
);
    line_cfg_t cfg_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int REG_IDX = g / LINES_PER_REG;
        localparam int SLOT    = g % LINES_PER_REG;
        logic hit;

        assign hit = wr_en && (wr_addr == ADDR_W'(REG_IDX));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= CFG_RESET;
            end else if (hit) begin
                cfg_q[g] <= '{level:    wr_data[OFS_LEVEL + SLOT],
                              sense:    wr_data[OFS_SENSE + SLOT],
                              any_edge: wr_data[OFS_ANY + SLOT],
                              enable:   wr_data[OFS_EN + SLOT]};
            end
        end

        assign clr_o[g] = hit && wr_data[OFS_CLR + SLOT];
        assign cfg_o[g] = cfg_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (ADDR_W'(i / LINES_PER_REG) == rd_addr) begin
                rd_data[OFS_EN    + i % LINES_PER_REG] = cfg_q[i].enable;
                rd_data[OFS_SENSE + i % LINES_PER_REG] = cfg_q[i].sense;
                rd_data[OFS_LEVEL + i % LINES_PER_REG] = cfg_q[i].level;
                rd_data[OFS_ANY   + i % LINES_PER_REG] = cfg_q[i].any_edge;
            end
        end
    end
endmodule

// File: rtl/xirq_line.sv
module xirq_line
    import xirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_s,
    input  line_cfg_t cfg,
    input  logic      clr,
    output logic      req_o
);
    line_state_e state_q, state_d;
    logic        pin_prev_q;
    logic        rise, fall, hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev_q <= 1'b0;
        end else begin
            pin_prev_q <= pin_s;
        end
    end

    assign rise = pin_s & ~pin_prev_q;
    assign fall = ~pin_s & pin_prev_q;
    assign hit  = cfg.any_edge ? (rise | fall) : (cfg.sense ? rise : fall);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (!cfg.level && hit) state_d = LN_LATCHED;      // capture
            end
            LN_LATCHED: begin
                if (cfg.level)         state_d = LN_IDLE;         // level_flush
                else if (hit)          state_d = LN_LATCHED;      // retrigger
                else if (clr)          state_d = LN_IDLE;         // ack
            end
            default:                   state_d = LN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        if (cfg.level) begin
            req_o = cfg.enable & (pin_s == cfg.sense);
        end else begin
            req_o = cfg.enable & (state_q == LN_LATCHED);
        end
    end

    // R3
    edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && hit) |=> (state_q == LN_LATCHED));

    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.level && clr && !hit && state_q == LN_LATCHED) |=> (state_q == LN_IDLE));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_LATCHED && !clr && !cfg.level) |=> (state_q == LN_LATCHED));

    // R9
    level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.level |=> (state_q == LN_IDLE));
endmodule

// File: rtl/xirq_trigger_ctrl.sv
module xirq_trigger_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_LINES   = 6,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_REGS   = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG,
    localparam int ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_pin,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [19:0]          wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [19:0]          rd_data,
    output logic [NUM_LINES-1:0] line_req,
    output logic                 any_req
);
    line_cfg_t            cfg [NUM_LINES];
    logic [NUM_LINES-1:0] clr;
    logic [NUM_LINES-1:0] pin_s;

    xirq_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg_o   (cfg),
        .clr_o   (clr)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_ln
        xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (ext_pin[g]),
            .q_o   (pin_s[g])
        );
        xirq_line u_line (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_s (pin_s[g]),
            .cfg   (cfg[g]),
            .clr   (clr[g]),
            .req_o (line_req[g])
        );

        // R5
        mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[g].enable |-> !line_req[g]);
    end

    assign any_req = |line_req;
endmodule

// File: tb/xirq_trigger_ctrl_tb.sv
module xirq_trigger_ctrl_tb_top;
    localparam int  N       = 6;
    localparam time CLK_PER = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] ext_pin = '0;
    logic         wr_en = 1'b0;
    logic [0:0]   wr_addr = '0;
    logic [19:0]  wr_data = '0;
    logic [0:0]   rd_addr = '0;
    logic [19:0]  rd_data;
    logic [N-1:0] line_req;
    logic         any_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    bit m_lvl [N];
    bit m_sen [N];
    bit m_any [N];
    bit m_en  [N];
    bit m_lat [N];
    logic [N-1:0] m_pin = '0;

    always #(CLK_PER/2) clk = ~clk;

    xirq_trigger_ctrl #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .line_req(line_req), .any_req(any_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] exp_req();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (m_lvl[i]) r[i] = m_en[i] & (m_pin[i] == m_sen[i]);
            else          r[i] = m_en[i] & m_lat[i];
        end
        return r;
    endfunction

    function automatic logic [19:0] exp_reg(input int r);
        logic [19:0] d = '0;
        for (int i = 0; i < N; i++) begin
            if (i / 4 == r) begin
                d[i % 4]      = m_en[i];
                d[8 + i % 4]  = m_sen[i];
                d[12 + i % 4] = m_lvl[i];
                d[16 + i % 4] = m_any[i];
            end
        end
        return d;
    endfunction

    task automatic check_out(input string tag);
        logic [N-1:0] e = exp_req();
        check(line_req === e, tag, int'(line_req), int'(e));
        check(any_req === (|e), "R8", int'(any_req), int'(|e));
    endtask

    task automatic check_rd(input int r, input string tag);
        logic [19:0] e = exp_reg(r);
        @(negedge clk);
        rd_addr = 1'(r);
        #1;
        check(rd_data === e, tag, int'(rd_data), int'(e));
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk);
        ext_pin = v;
        for (int i = 0; i < N; i++) begin
            bit rise = v[i] & ~m_pin[i];
            bit fall = ~v[i] & m_pin[i];
            bit hit  = m_any[i] ? (rise | fall) : (m_sen[i] ? rise : fall);
            if (!m_lvl[i] && hit) m_lat[i] = 1'b1;
        end
        m_pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input int i, input bit lvl, input bit sen, input bit any_e, input bit en);
        m_lvl[i] = lvl; m_sen[i] = sen; m_any[i] = any_e; m_en[i] = en;
    endtask

    task automatic write_reg(input int r, input logic [3:0] clr_bits);
        logic [19:0] d = exp_reg(r);
        d[7:4] = clr_bits;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 1'(r); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (i / 4 == r) begin
                if (clr_bits[i % 4] || m_lvl[i]) m_lat[i] = 1'b0;
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            set_cfg(i, 1'b1, 1'b0, 1'b0, 1'b0);
            m_lat[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state and R7 layout of both registers
        check(line_req === '0, "R1", int'(line_req), 0);
        check(any_req === 1'b0, "R1", int'(any_req), 0);
        check_rd(0, "R1");
        check(rd_data === 20'h0F000, "R7", int'(rd_data), 'h0F000);
        check_rd(1, "R7");
        check(rd_data === 20'h03000, "R7", int'(rd_data), 'h03000);

        // R3 rising edge on line 0, holds after the pin falls
        set_cfg(0, 1'b0, 1'b1, 1'b0, 1'b1);
        set_cfg(1, 1'b0, 1'b0, 1'b0, 1'b1);
        set_cfg(2, 1'b0, 1'b0, 1'b1, 1'b1);
        set_cfg(3, 1'b1, 1'b1, 1'b0, 1'b1);
        write_reg(0, 4'b0000);
        check_out("R3");
        set_pins(6'b000001);
        check_out("R3");
        check(line_req[0] === 1'b1, "R3", int'(line_req[0]), 1);
        set_pins(6'b000000);
        check_out("R3");
        // R6 clear drops latch
        write_reg(0, 4'b0001);
        check_out("R6");
        check(line_req[0] === 1'b0, "R6", int'(line_req[0]), 0);

        // R3 falling edge on line 1
        set_pins(6'b000010);
        check(line_req[1] === 1'b0, "R3", int'(line_req[1]), 0);
        set_pins(6'b000000);
        check(line_req[1] === 1'b1, "R3", int'(line_req[1]), 1);
        write_reg(0, 4'b0010);

        // R4 any edge on line 2
        set_pins(6'b000100);
        check(line_req[2] === 1'b1, "R4", int'(line_req[2]), 1);
        write_reg(0, 4'b0100);
        check(line_req[2] === 1'b0, "R4", int'(line_req[2]), 0);
        set_pins(6'b000000);
        check(line_req[2] === 1'b1, "R4", int'(line_req[2]), 1);
        write_reg(0, 4'b0100);

        // R2 level high on line 3
        set_pins(6'b001000);
        check(line_req[3] === 1'b1, "R2", int'(line_req[3]), 1);
        // R6 clear ignored in level mode
        write_reg(0, 4'b1000);
        check(line_req[3] === 1'b1, "R6", int'(line_req[3]), 1);
        set_pins(6'b000000);
        check(line_req[3] === 1'b0, "R2", int'(line_req[3]), 0);
        // R9 any-edge bit ignored with level-select
        set_cfg(3, 1'b1, 1'b1, 1'b1, 1'b1);
        write_reg(0, 4'b0000);
        set_pins(6'b001000);
        check(line_req[3] === 1'b1, "R9", int'(line_req[3]), 1);
        set_pins(6'b000000);
        check(line_req[3] === 1'b0, "R9", int'(line_req[3]), 0);

        // R2 active-low level on line 4 (second register)
        set_cfg(4, 1'b1, 1'b0, 1'b0, 1'b1);
        set_cfg(5, 1'b0, 1'b1, 1'b0, 1'b0);
        write_reg(1, 4'b0000);
        check(line_req[4] === 1'b1, "R2", int'(line_req[4]), 1);
        // R5 edge recorded while disabled on line 5
        set_pins(6'b100000);
        check(line_req[5] === 1'b0, "R5", int'(line_req[5]), 0);
        set_cfg(5, 1'b0, 1'b1, 1'b0, 1'b1);
        write_reg(1, 4'b0000);
        check(line_req[5] === 1'b1, "R5", int'(line_req[5]), 1);
        check_out("R5");
        check_rd(1, "R7");

        // Random mix against the model
        for (int k = 0; k < 400; k++) begin
            int act = $urandom_range(0, 9);
            if (act < 5) begin
                set_pins(N'($urandom));
                check_out("R2/R3/R4");
            end else if (act < 9) begin
                int r = $urandom_range(0, 1);
                for (int i = r * 4; i < N && i < r * 4 + 4; i++)
                    set_cfg(i, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
                write_reg(r, 4'($urandom));
                check_out("R5/R6");
            end else begin
                check_rd($urandom_range(0, 1), "R7");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule